// File: doc/BRIEF.md
# Phase-Realignable Clock Halver

This block runs in the fast input clock domain. It produces a registered half-rate clock that toggles on every input edge, together with a one-cycle enable that marks each rising edge of that half-rate clock. Logic on the host side can use the enable to work at the slow rate while it stays in the fast domain.

A three-bit mode input carries commands. The all-zero code is the reset command. The block decodes it into a registered host reset output. The reset command never stops or clears the divider.

The reset command can also shift the phase of the half-rate clock. When the command first appears while the half-rate clock is low, the clock rises on the next edge and then stays high for one extra input cycle. This moves the phase by one input period. When the command first appears while the half-rate clock is high, the phase does not change. The host can therefore pulse the reset command to bring the half-rate clock to a known phase relative to its own timing. The power-on reset input only initialises the registers.

Top module: `clkhalf_realign`

## Requirements
- R1: `host_rst_o` is high in the cycle after each rising input edge at which `mode_i` equals 3'b000. It is low in the cycle after each edge at which `mode_i` holds any other code.
- R2: While no phase slip is in progress, `half_clk_o` inverts on every rising input edge, so it has a period of two input cycles.
- R3: If `mode_i` changes to 3'b000 at an edge where `half_clk_o` is high, the output keeps its phase. The next four output values are 0, 1, 0, 1.
- R4: If `mode_i` changes to 3'b000 at an edge where `half_clk_o` is low, the output goes high at that edge and stays high for HOLD_CYCLES (default 2) input cycles. It then goes low for one cycle and rises again. With the defaults, the next four output values are 1, 1, 0, 1.
- R5: A phase slip is triggered only at the first edge of an unbroken run of the reset code. Holding the code does not trigger another slip. The trigger re-arms once a different code has been seen.
- R6: `rise_en_o` is high for exactly the cycles in which `half_clk_o` has just gone from low to high.
- R7: While `rst_ni` is low, `half_clk_o`, `rise_en_o` and `host_rst_o` are all low.
- R8: While the reset code is held, the divider keeps running. Any 40-cycle window in steady state contains 20 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mode_i | input | 3 | Command code; 3'b000 is the reset command |
| half_clk_o | output | 1 | Registered half-rate clock |
| rise_en_o | output | 1 | One-cycle marker of each half-rate rising edge |
| host_rst_o | output | 1 | Registered decode of the reset command |

## Verification
The assertions assume that `mode_i` changes only between rising input edges, so that every edge samples a single settled code. They also assume that HOLD_CYCLES is at least 2, which makes a slip visible as two consecutive high cycles. The bench drives `mode_i` only on falling edges. Its random stimulus holds each code for a random number of cycles and favours the reset code, so that first-edge triggers fall on both output phases and long held runs also occur.

// File: rtl/clkhalf_pkg.sv
package clkhalf_pkg;

    localparam int unsigned MODE_W = 3;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_RESET = '0;

    typedef struct packed {
        logic seen;
        logic cmd;
    } decode_state_t;

endpackage

// File: rtl/clkhalf_cmd_decode.sv
module clkhalf_cmd_decode
    import clkhalf_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  mode_t mode_i,
    output logic  first_o,
    output logic  cmd_o
);

    decode_state_t st_d, st_q;
    logic          is_reset;

    always_comb begin
        is_reset = (mode_i == MODE_RESET);
        st_d     = st_q;
        st_d.seen = is_reset;
        st_d.cmd  = is_reset;
        first_o   = is_reset && !st_q.seen;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o = st_q.cmd;

    AST_FIRST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_o |=> !first_o) else $error("first-edge trigger repeated"); // R5

    AST_FIRST_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_o |=> cmd_o) else $error("trigger without command"); // R1

endmodule

// File: rtl/clkhalf_phase_core.sv
module clkhalf_phase_core #(
    parameter int unsigned HOLD_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slip_req_i,
    output logic half_clk_o,
    output logic rise_o
);

    localparam int unsigned HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    typedef struct packed {
        logic          half;
        logic          rise;
        logic [HW-1:0] hold;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hold != '0) begin
            st_d.half = 1'b1;
            st_d.hold = st_q.hold - HW'(1);
        end else if (slip_req_i && !st_q.half) begin
            st_d.half = 1'b1;
            st_d.hold = HW'(HOLD_CYCLES - 1);
        end else begin
            st_d.half = !st_q.half;
        end
        st_d.rise = st_d.half && !st_q.half;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_clk_o = st_q.half;
    assign rise_o     = st_q.rise;

    AST_LOW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !half_clk_o |=> half_clk_o) else $error("low phase stretched"); // R2

    AST_HIGH_NO_SLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (half_clk_o && st_q.hold == '0) |=> !half_clk_o) else $error("high phase stretched"); // R3

    AST_SLIP_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_req_i && !half_clk_o) |=> half_clk_o ##1 half_clk_o) else $error("slip missing"); // R4

    AST_RISE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(half_clk_o) |-> rise_o) else $error("rise marker missing"); // R6

    AST_RISE_ONLY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> half_clk_o) else $error("rise marker while low"); // R6

endmodule

// File: rtl/clkhalf_realign.sv
module clkhalf_realign
    import clkhalf_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    output logic              half_clk_o,
    output logic              rise_en_o,
    output logic              host_rst_o
);

    logic slip_req;

    clkhalf_cmd_decode i_decode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode_i),
        .first_o (slip_req),
        .cmd_o   (host_rst_o)
    );

    clkhalf_phase_core #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .slip_req_i (slip_req),
        .half_clk_o (half_clk_o),
        .rise_o     (rise_en_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> (!half_clk_o && !rise_en_o && !host_rst_o)) else $error("outputs active in reset"); // R7

    AST_CMD_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_RESET) |=> host_rst_o) else $error("command not decoded"); // R1

endmodule

// File: tb/test_clkhalf_realign.sv
module test_clkhalf_realign;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] mode_i = 3'd3;
    logic       half_clk_o, rise_en_o, host_rst_o;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic m_half = 0, m_rise = 0, m_cmd = 0, m_seen = 0;
    int   m_hold = 0;
    string cur_tag = "R2";

    clkhalf_realign i_clkhalf_realign (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_i),
        .half_clk_o (half_clk_o),
        .rise_en_o  (rise_en_o),
        .host_rst_o (host_rst_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected next state per the requirements, for a code sampled at an edge.
    task automatic model_edge(logic [2:0] m);
        logic first, nh;
        first = (m == 3'd0) && !m_seen;
        if (m_hold > 0) begin
            nh = 1'b1;
            m_hold--;
        end else if (first && !m_half) begin
            nh = 1'b1;
            m_hold = 1; // HOLD_CYCLES - 1
        end else begin
            nh = !m_half;
        end
        m_rise = nh && !m_half;
        m_half = nh;
        m_seen = (m == 3'd0);
        m_cmd  = (m == 3'd0);
    endtask

    // Drive a code, let one edge pass, compare at the falling edge.
    task automatic step(logic [2:0] m);
        mode_i = m;
        model_edge(m);
        @(negedge clk_i);
        cmp(cur_tag, "half_clk", int'(half_clk_o), int'(m_half));
        cmp("R6", "rise_en", int'(rise_en_o), int'(m_rise));
        cmp("R1", "host_rst", int'(host_rst_o), int'(m_cmd));
    endtask

    task automatic to_phase(logic want);
        while (m_half != want) step(3'd5);
    endtask

    initial begin
        #(10 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] seq;
        int rises;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk_i);
        cmp("R7", "half_clk in reset", int'(half_clk_o), 0);
        cmp("R7", "rise_en in reset", int'(rise_en_o), 0);
        cmp("R7", "host_rst in reset", int'(host_rst_o), 0);
        rst_ni = 1'b1;

        // R2: free running toggle
        cur_tag = "R2";
        repeat (8) step(3'd3);

        // R3: command arrives while output high
        cur_tag = "R3";
        to_phase(1'b1);
        for (int i = 0; i < 4; i++) begin
            step(3'd0);
            seq[3-i] = half_clk_o;
        end
        cmp("R3", "sequence after command while high", int'(seq), 4'b0101);

        // R4: command arrives while output low
        cur_tag = "R4";
        step(3'd2);
        to_phase(1'b0);
        for (int i = 0; i < 4; i++) begin
            step(3'd0);
            seq[3-i] = half_clk_o;
        end
        cmp("R4", "sequence after command while low", int'(seq), 4'b1101);

        // R5: held code gives no further slip; R8: divider keeps running
        cur_tag = "R5";
        repeat (6) step(3'd0);
        cur_tag = "R8";
        rises = 0;
        for (int i = 0; i < 40; i++) begin
            step(3'd0);
            if (rise_en_o) rises++;
        end
        cmp("R8", "rising edges in 40 cycles under held command", rises, 20);

        // R5: re-arm after another code
        cur_tag = "R5";
        step(3'd7);
        to_phase(1'b0);
        for (int i = 0; i < 4; i++) begin
            step(3'd0);
            seq[3-i] = half_clk_o;
        end
        cmp("R5", "slip re-armed", int'(seq), 4'b1101);

        // R2 frequency in steady state
        cur_tag = "R2";
        rises = 0;
        for (int i = 0; i < 40; i++) begin
            step(3'd6);
            if (rise_en_o) rises++;
        end
        cmp("R2", "rising edges in 40 free cycles", rises, 20);

        // Random runs of codes, reset code favoured
        cur_tag = "R4";
        for (int n = 0; n < 400; n++) begin
            logic [2:0] code;
            int len;
            code = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom % 8);
            len  = 1 + int'($urandom % 6);
            for (int k = 0; k < len; k++) step(code);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule